// File: doc/BRIEF.md
# Instruction Byte Queue Picker

This block sits between instruction fetch and the decoders. Fetch delivers 16-byte chunks of instruction bytes. Predecode adds a per-byte end marker and a start-byte offset that skips the bytes in front of a branch target that is not aligned. The chunks land in a circular queue of 16-byte entries. Each cycle the picker reads the head entry and the entry after it as one 32-byte window. It then hands up to four whole instructions to decode, each given as a byte offset into the window and a length.

The window always starts at the first byte of the head entry. A byte cursor inside the head entry records where the next instruction starts. Instructions are handed out in byte order, one per pick slot. Only slot 0 may take an instruction longer than the long-instruction limit. When such an instruction would fall into a later slot, picking stops in front of it, and the instruction goes to slot 0 on the following cycle. When the cursor passes the end of the head entry, or of both entries, those entries are retired. The retire count is reported along with the picks.

The picks and the window bytes are registered outputs: they describe the queue as it stood before the previous clock edge. A flush empties the queue in one cycle and clears the cursor.

Top module: `ibyte_pick_queue`

## Requirements
- R1: The queue holds DEPTH (20) entries of 16 bytes. `fetch_ready` is a registered flag that is high while at least 2 entries are free after the last edge. With nothing retiring, 19 chunks are accepted from empty before it drops. A chunk offered while it is low is not stored.
- R2: `flush` empties the queue and zeroes the cursor at one edge. After that edge `pick_valid` is 0 and `fetch_ready` is 1. The next pushed chunk is picked from its byte 0.
- R3: Window bytes 0..15 are the head entry and bytes 16..31 are the next entry. `pick_window` carries them with window byte b at bits [8b+7:8b], and a half whose entry is absent reads as zero. Offsets are relative to the window base.
- R4: At most 4 instructions are picked per cycle. Valid slots are contiguous from slot 0, and their offsets rise with the slot number.
- R5: Bit i of `fetch_ends` set means byte i of the chunk is the last byte of an instruction. An instruction runs from its start byte to the first end marker at or after it, and its length is end - start + 1.
- R6: Only slot 0 may hold an instruction longer than 8 bytes. A longer instruction that would fall into slot 1, 2 or 3 stops picking for the cycle and is picked in slot 0 on the next cycle. A length of exactly 8 is allowed in any slot.
- R7: An instruction whose end marker is not inside the window is not picked until the entry that holds its end is present.
- R8: `pick_adv` (0, 1 or 2) gives the entries retired with the picks. An entry is retired once the cursor has passed its last byte. The cursor carries into the new head at the byte after the last picked end.
- R9: `fetch_skip` on a chunk gives the first byte of the chunk that belongs to an instruction. When that entry becomes the head, picking starts at the larger of the carried cursor and the skip. When the cursor reaches byte 16 of the window within a cycle, it jumps to 16 plus the next entry's skip.
- R10: A chunk written at an edge is first seen by the picker in the following cycle, and its picks appear on the outputs one edge later.
- R11: After reset the queue is empty, `fetch_ready` is 1, `pick_valid` is 0 and `pick_adv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the queue and clear the cursor |
| fetch_valid | input | 1 | A chunk is offered |
| fetch_bytes | input | 128 | Chunk bytes, byte i at bits [8i+7:8i] |
| fetch_ends | input | 16 | Per-byte end-of-instruction markers |
| fetch_skip | input | 4 | First useful byte of the chunk |
| fetch_ready | output | 1 | Queue can take a chunk |
| pick_valid | output | 4 | Per-slot pick valid |
| pick_off | output | 20 | Per-slot window offset, 5 bits per slot, slot 0 lowest |
| pick_len | output | 24 | Per-slot length, 6 bits per slot, slot 0 lowest |
| pick_adv | output | 2 | Entries retired with these picks |
| pick_window | output | 256 | The 32-byte window the picks refer to |

## Verification
The bench targets a long instruction in slots 1 and 3, where a design that ignores the slot rule would hand four picks to decode instead of stopping. It also tests a length of exactly 8 in a late slot, which an off-by-one design would wrongly refuse. Other cases cover an instruction that crosses into an entry that has not arrived yet, and a cursor that lands on the entry boundary inside a cycle where the next entry carries a skip. A design that picked early would emit a truncated length there, and one that ignored the skip would report offset 16 and a bad length. A two-entry retire and a queue held full by unterminated bytes show whether the retire count and the ready threshold are off by one. A final flush shows whether stale entries or a stale cursor survive.

// File: rtl/ibq_pkg.sv
package ibq_pkg;

  // Number of queue entries retired in one cycle.
  typedef enum logic [1:0] {
    ADV_HOLD = 2'd0,
    ADV_ONE  = 2'd1,
    ADV_TWO  = 2'd2
  } adv_e;

endpackage

// File: rtl/ibq_store.sv
// Circular entry store: bytes, end markers and skip offset per entry.
module ibq_store
  import ibq_pkg::*;
#(
  parameter int unsigned DEPTH = 20,
  parameter int unsigned EB    = 16,
  localparam int unsigned SKW  = $clog2(EB),
  localparam int unsigned PTRW = $clog2(DEPTH),
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            push,
  input  logic [EB*8-1:0] wr_bytes,
  input  logic [EB-1:0]   wr_ends,
  input  logic [SKW-1:0]  wr_skip,
  input  adv_e            adv,
  output logic [CNTW-1:0] occ,
  output logic            ready,
  output logic [EB*8-1:0] h0_bytes,
  output logic [EB-1:0]   h0_ends,
  output logic [SKW-1:0]  h0_skip,
  output logic [EB*8-1:0] h1_bytes,
  output logic [EB-1:0]   h1_ends,
  output logic [SKW-1:0]  h1_skip
);

  localparam int unsigned PW1 = PTRW + 1;

  logic [EB*8-1:0] byte_mem [DEPTH];
  logic [EB-1:0]   ends_mem [DEPTH];
  logic [SKW-1:0]  skip_mem [DEPTH];

  logic [PTRW-1:0] head_q, tail_q, head_p1;
  logic [CNTW-1:0] occ_q, occ_n;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p,
                                           input logic [1:0] n);
    logic [PW1-1:0] s;
    s = {1'b0, p} + PW1'(n);
    if (s >= PW1'(DEPTH)) s = s - PW1'(DEPTH);
    return s[PTRW-1:0];
  endfunction

  assign head_p1 = bump(head_q, 2'd1);

  // Entry memories: plain write port, two asynchronous read ports.
  always_ff @(posedge clk) begin
    if (push) begin
      byte_mem[tail_q] <= wr_bytes;
      ends_mem[tail_q] <= wr_ends;
      skip_mem[tail_q] <= wr_skip;
    end
  end

  assign h0_bytes = byte_mem[head_q];
  assign h0_ends  = ends_mem[head_q];
  assign h0_skip  = skip_mem[head_q];
  assign h1_bytes = byte_mem[head_p1];
  assign h1_ends  = ends_mem[head_p1];
  assign h1_skip  = skip_mem[head_p1];

  always_comb begin
    if (flush) occ_n = '0;
    else       occ_n = occ_q + CNTW'(push) - CNTW'(adv);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
      ready  <= 1'b1;
    end else begin
      head_q <= bump(head_q, adv);
      if (push) tail_q <= bump(tail_q, 2'd1);
      occ_q  <= occ_n;
      ready  <= (occ_n <= CNTW'(DEPTH - 2));
    end
  end

  assign occ = occ_q;

endmodule

// File: rtl/ibq_slot.sv
// One pick slot: finds the instruction starting at cur inside the window.
module ibq_slot #(
  parameter int unsigned EB         = 16,
  parameter int unsigned LONG_MAX   = 8,
  parameter bit          ALLOW_LONG = 1'b0,
  localparam int unsigned WB   = 2 * EB,
  localparam int unsigned OFFW = $clog2(WB),
  localparam int unsigned CW   = OFFW + 1,
  localparam int unsigned SKW  = $clog2(EB)
) (
  input  logic            live,
  input  logic [CW-1:0]   cur,
  input  logic [WB-1:0]   ends,
  input  logic [SKW-1:0]  skip1,
  output logic            hit,
  output logic [OFFW-1:0] off,
  output logic [CW-1:0]   len,
  output logic [CW-1:0]   nxt
);

  logic            found;
  logic [OFFW-1:0] k;
  logic [CW-1:0]   span;
  logic [CW-1:0]   after;
  logic            too_long;

  // Lowest end marker at or above the cursor.
  always_comb begin
    found = 1'b0;
    k     = '0;
    for (int i = WB - 1; i >= 0; i--) begin
      if (ends[i] && (CW'(i) >= cur)) begin
        found = 1'b1;
        k     = OFFW'(i);
      end
    end
  end

  always_comb begin
    span     = {1'b0, k} - cur + CW'(1);
    too_long = !ALLOW_LONG && (span > CW'(LONG_MAX));
    hit      = live && found && !too_long;
    after    = {1'b0, k} + CW'(1);
    if (after == CW'(EB)) after = CW'(EB) + CW'(skip1);
    off = hit ? cur[OFFW-1:0] : '0;
    len = hit ? span : '0;
    nxt = hit ? after : cur;
  end

endmodule

// File: rtl/ibq_pick.sv
// Chains the pick slots across one window and works out the retire count.
module ibq_pick
  import ibq_pkg::*;
#(
  parameter int unsigned SLOTS    = 4,
  parameter int unsigned EB       = 16,
  parameter int unsigned LONG_MAX = 8,
  localparam int unsigned WB   = 2 * EB,
  localparam int unsigned OFFW = $clog2(WB),
  localparam int unsigned CW   = OFFW + 1,
  localparam int unsigned SKW  = $clog2(EB)
) (
  input  logic [SKW-1:0]        pos,
  input  logic                  avail0,
  input  logic                  avail1,
  input  logic [EB-1:0]         e0_ends,
  input  logic [EB-1:0]         e1_ends,
  input  logic [SKW-1:0]        skip0,
  input  logic [SKW-1:0]        skip1,
  output logic [SLOTS-1:0]      hit,
  output logic [SLOTS*OFFW-1:0] off,
  output logic [SLOTS*CW-1:0]   len,
  output adv_e                  adv,
  output logic [SKW-1:0]        pos_n
);

  logic [WB-1:0]  win_ends;
  logic [SKW-1:0] start;
  logic [SKW-1:0] skip1_g;
  logic [CW-1:0]  cur_c  [SLOTS+1];
  logic           live_c [SLOTS+1];
  logic [CW-1:0]  fin;

  assign win_ends = {(avail1 ? e1_ends : {EB{1'b0}}),
                     (avail0 ? e0_ends : {EB{1'b0}})};
  assign skip1_g  = avail1 ? skip1 : '0;
  assign start    = (avail0 && (skip0 > pos)) ? skip0 : pos;
  assign cur_c[0]  = CW'(start);
  assign live_c[0] = avail0;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    ibq_slot #(
      .EB        (EB),
      .LONG_MAX  (LONG_MAX),
      .ALLOW_LONG(s == 0)
    ) u_slot (
      .live (live_c[s]),
      .cur  (cur_c[s]),
      .ends (win_ends),
      .skip1(skip1_g),
      .hit  (hit[s]),
      .off  (off[s*OFFW +: OFFW]),
      .len  (len[s*CW +: CW]),
      .nxt  (cur_c[s+1])
    );
    assign live_c[s+1] = hit[s];
  end

  assign fin = cur_c[SLOTS];

  always_comb begin
    if (fin >= CW'(WB)) begin
      adv   = ADV_TWO;
      pos_n = '0;
    end else if (fin >= CW'(EB)) begin
      adv   = ADV_ONE;
      pos_n = SKW'(fin - CW'(EB));
    end else begin
      adv   = ADV_HOLD;
      pos_n = SKW'(fin);
    end
  end

endmodule

// File: rtl/ibyte_pick_queue.sv
// Instruction byte queue with a four-slot picker over a 32-byte window.
module ibyte_pick_queue
  import ibq_pkg::*;
#(
  parameter int unsigned DEPTH    = 20,
  parameter int unsigned EB       = 16,
  parameter int unsigned SLOTS    = 4,
  parameter int unsigned LONG_MAX = 8,
  localparam int unsigned WB   = 2 * EB,
  localparam int unsigned OFFW = $clog2(WB),
  localparam int unsigned LENW = OFFW + 1,
  localparam int unsigned SKW  = $clog2(EB),
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  fetch_valid,
  input  logic [EB*8-1:0]       fetch_bytes,
  input  logic [EB-1:0]         fetch_ends,
  input  logic [SKW-1:0]        fetch_skip,
  output logic                  fetch_ready,
  output logic [SLOTS-1:0]      pick_valid,
  output logic [SLOTS*OFFW-1:0] pick_off,
  output logic [SLOTS*LENW-1:0] pick_len,
  output logic [1:0]            pick_adv,
  output logic [WB*8-1:0]       pick_window
);

  logic            push;
  logic [CNTW-1:0] occ;
  logic            avail0, avail1;
  logic [EB*8-1:0] h0_bytes, h1_bytes;
  logic [EB-1:0]   h0_ends, h1_ends;
  logic [SKW-1:0]  h0_skip, h1_skip;
  logic [SKW-1:0]  pos_q, pos_n;
  adv_e            adv;

  logic [SLOTS-1:0]      hit;
  logic [SLOTS*OFFW-1:0] off_c;
  logic [SLOTS*LENW-1:0] len_c;

  assign push   = fetch_valid && fetch_ready && !flush;
  assign avail0 = (occ >= CNTW'(1));
  assign avail1 = (occ >= CNTW'(2));

  ibq_store #(
    .DEPTH(DEPTH),
    .EB   (EB)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .push    (push),
    .wr_bytes(fetch_bytes),
    .wr_ends (fetch_ends),
    .wr_skip (fetch_skip),
    .adv     (adv),
    .occ     (occ),
    .ready   (fetch_ready),
    .h0_bytes(h0_bytes),
    .h0_ends (h0_ends),
    .h0_skip (h0_skip),
    .h1_bytes(h1_bytes),
    .h1_ends (h1_ends),
    .h1_skip (h1_skip)
  );

  ibq_pick #(
    .SLOTS   (SLOTS),
    .EB      (EB),
    .LONG_MAX(LONG_MAX)
  ) u_pick (
    .pos    (pos_q),
    .avail0 (avail0),
    .avail1 (avail1),
    .e0_ends(h0_ends),
    .e1_ends(h1_ends),
    .skip0  (h0_skip),
    .skip1  (h1_skip),
    .hit    (hit),
    .off    (off_c),
    .len    (len_c),
    .adv    (adv),
    .pos_n  (pos_n)
  );

  // Cursor inside the head entry.
  always_ff @(posedge clk) begin
    if (rst || flush) pos_q <= '0;
    else              pos_q <= pos_n;
  end

  // Registered pick outputs.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pick_valid  <= '0;
      pick_off    <= '0;
      pick_len    <= '0;
      pick_adv    <= '0;
      pick_window <= '0;
    end else begin
      pick_valid  <= hit;
      pick_off    <= off_c;
      pick_len    <= len_c;
      pick_adv    <= adv;
      pick_window <= {(avail1 ? h1_bytes : {(EB*8){1'b0}}),
                      (avail0 ? h0_bytes : {(EB*8){1'b0}})};
    end
  end

endmodule

// File: rtl/ibq_checker.sv
// Temporal properties of the picker, attached to the top with bind.
module ibq_checker #(
  parameter int unsigned DEPTH    = 20,
  parameter int unsigned SLOTS    = 4,
  parameter int unsigned OFFW     = 5,
  parameter int unsigned LENW     = 6,
  parameter int unsigned CNTW     = 5,
  parameter int unsigned LONG_MAX = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  flush,
  input logic                  fetch_valid,
  input logic                  fetch_ready,
  input logic [CNTW-1:0]       occ,
  input logic [SLOTS-1:0]      pick_valid,
  input logic [SLOTS*OFFW-1:0] pick_off,
  input logic [SLOTS*LENW-1:0] pick_len,
  input logic [1:0]            pick_adv
);

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    occ <= CNTW'(DEPTH));

  p_refused_push_r1: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_ready && !flush) |=> (occ <= $past(occ)));

  p_flush_empties_r2: assert property (@(posedge clk) disable iff (rst)
    flush |=> (pick_valid == '0 && fetch_ready && occ == '0));

  p_slots_contiguous_r4: assert property (@(posedge clk) disable iff (rst)
    ((pick_valid & (pick_valid + SLOTS'(1))) == '0));

  p_len_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    pick_valid[0] |-> (pick_len[LENW-1:0] != '0));

  p_adv_range_r8: assert property (@(posedge clk) disable iff (rst)
    pick_adv != 2'd3);

  p_reset_state_r11: assert property (@(posedge clk)
    rst |=> (pick_valid == '0 && fetch_ready && pick_adv == 2'd0));

  for (genvar s = 1; s < SLOTS; s++) begin : g_late
    p_long_only_slot0_r6: assert property (@(posedge clk) disable iff (rst)
      pick_valid[s] |-> (pick_len[s*LENW +: LENW] <= LENW'(LONG_MAX)));

    p_offsets_rise_r4: assert property (@(posedge clk) disable iff (rst)
      pick_valid[s] |->
        ((LENW + 1)'(pick_off[s*OFFW +: OFFW]) >=
         (LENW + 1)'(pick_off[(s-1)*OFFW +: OFFW]) +
         (LENW + 1)'(pick_len[(s-1)*LENW +: LENW])));
  end

endmodule

bind ibyte_pick_queue ibq_checker #(
  .DEPTH   (DEPTH),
  .SLOTS   (SLOTS),
  .OFFW    (OFFW),
  .LENW    (LENW),
  .CNTW    (CNTW),
  .LONG_MAX(LONG_MAX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .fetch_valid(fetch_valid),
  .fetch_ready(fetch_ready),
  .occ        (occ),
  .pick_valid (pick_valid),
  .pick_off   (pick_off),
  .pick_len   (pick_len),
  .pick_adv   (pick_adv)
);

// File: tb/ibyte_pick_queue_bench.sv
`timescale 1ns/1ps
module ibyte_pick_queue_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         flush = 1'b0;
  logic         fetch_valid = 1'b0;
  logic [127:0] fetch_bytes = '0;
  logic [15:0]  fetch_ends = '0;
  logic [3:0]   fetch_skip = '0;
  logic         fetch_ready;
  logic [3:0]   pick_valid;
  logic [19:0]  pick_off;
  logic [23:0]  pick_len;
  logic [1:0]   pick_adv;
  logic [255:0] pick_window;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ibyte_pick_queue u_ibyte_pick_queue (
    .clk(clk), .rst(rst), .flush(flush),
    .fetch_valid(fetch_valid), .fetch_bytes(fetch_bytes),
    .fetch_ends(fetch_ends), .fetch_skip(fetch_skip),
    .fetch_ready(fetch_ready), .pick_valid(pick_valid),
    .pick_off(pick_off), .pick_len(pick_len),
    .pick_adv(pick_adv), .pick_window(pick_window)
  );

  // One vector: two chunks, then the picks after chunk A alone (c1)
  // and after both chunks (c2). Slot 3 is the leftmost field.
  typedef struct packed {
    logic [15:0]      ea;
    logic [15:0]      eb;
    logic [3:0]       ska;
    logic [3:0]       skb;
    logic [3:0]       v1;
    logic [1:0]       a1;
    logic [3:0][4:0]  o1;
    logic [3:0][5:0]  l1;
    logic [3:0]       v2;
    logic [1:0]       a2;
    logic [3:0][4:0]  o2;
    logic [3:0][5:0]  l2;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'h8888, 16'h8888, 4'd0, 4'd0,
      4'hF, 2'd1, {5'd12,5'd8,5'd4,5'd0},   {6'd4,6'd4,6'd4,6'd4},
      4'hF, 2'd1, {5'd12,5'd8,5'd4,5'd0},   {6'd4,6'd4,6'd4,6'd4}},
    '{16'h8802, 16'h8888, 4'd0, 4'd0,
      4'h1, 2'd0, {5'd0,5'd0,5'd0,5'd0},    {6'd0,6'd0,6'd0,6'd2},
      4'hF, 2'd1, {5'd20,5'd16,5'd12,5'd2}, {6'd4,6'd4,6'd4,6'd10}},
    '{16'h8200, 16'h8888, 4'd6, 4'd0,
      4'h3, 2'd1, {5'd0,5'd0,5'd10,5'd6},   {6'd0,6'd0,6'd6,6'd4},
      4'hF, 2'd1, {5'd12,5'd8,5'd4,5'd0},   {6'd4,6'd4,6'd4,6'd4}},
    '{16'h0410, 16'h8088, 4'd0, 4'd0,
      4'h3, 2'd0, {5'd0,5'd0,5'd5,5'd0},    {6'd0,6'd0,6'd6,6'd5},
      4'h7, 2'd2, {5'd0,5'd24,5'd20,5'd11}, {6'd0,6'd8,6'd4,6'd9}},
    '{16'h802A, 16'h8888, 4'd0, 4'd0,
      4'h7, 2'd0, {5'd0,5'd4,5'd2,5'd0},    {6'd0,6'd2,6'd2,6'd2},
      4'hF, 2'd1, {5'd24,5'd20,5'd16,5'd6}, {6'd4,6'd4,6'd4,6'd10}},
    '{16'hFFFF, 16'h8888, 4'd0, 4'd0,
      4'hF, 2'd0, {5'd3,5'd2,5'd1,5'd0},    {6'd1,6'd1,6'd1,6'd1},
      4'hF, 2'd0, {5'd7,5'd6,5'd5,5'd4},    {6'd1,6'd1,6'd1,6'd1}},
    '{16'h8202, 16'h8888, 4'd0, 4'd0,
      4'h7, 2'd1, {5'd0,5'd10,5'd2,5'd0},   {6'd0,6'd6,6'd8,6'd2},
      4'hF, 2'd1, {5'd12,5'd8,5'd4,5'd0},   {6'd4,6'd4,6'd4,6'd4}},
    '{16'h8002, 16'h8080, 4'd0, 4'd4,
      4'h1, 2'd0, {5'd0,5'd0,5'd0,5'd0},    {6'd0,6'd0,6'd0,6'd2},
      4'h7, 2'd2, {5'd0,5'd24,5'd20,5'd2},  {6'd0,6'd8,6'd4,6'd14}}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R5/R8";
      1: return "R6";
      2: return "R9";
      3: return "R7/R8";
      4: return "R6";
      5: return "R4";
      6: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [127:0] mk_bytes(int seed);
    logic [127:0] b;
    for (int j = 0; j < 16; j++) b[j*8 +: 8] = 8'(seed * 37 + j);
    return b;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [49:0] got();
    return {pick_valid, pick_adv, pick_off, pick_len};
  endfunction

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic run_vec(int i);
    vec_t v;
    logic [49:0] e1, e2;
    v  = VECS[i];
    e1 = {v.v1, v.a1, v.o1, v.l1};
    e2 = {v.v2, v.a2, v.o2, v.l2};
    do_flush();
    fetch_valid = 1'b1;
    fetch_bytes = mk_bytes(2 * i);
    fetch_ends  = v.ea;
    fetch_skip  = v.ska;
    @(negedge clk);
    chk(pick_valid == 4'h0, "R10", 256'(pick_valid), 256'(0));
    fetch_bytes = mk_bytes(2 * i + 1);
    fetch_ends  = v.eb;
    fetch_skip  = v.skb;
    @(negedge clk);
    fetch_valid = 1'b0;
    chk(got() == e1, vtag(i), 256'(got()), 256'(e1));
    if (i == 0)
      chk(pick_window == {128'h0, mk_bytes(0)}, "R3",
          pick_window, {128'h0, mk_bytes(0)});
    @(negedge clk);
    chk(got() == e2, vtag(i), 256'(got()), 256'(e2));
    if (i == 0)
      chk(pick_window == {128'h0, mk_bytes(1)}, "R3",
          pick_window, {128'h0, mk_bytes(1)});
    if (i == 1)
      chk(pick_window == {mk_bytes(3), mk_bytes(2)}, "R3",
          pick_window, {mk_bytes(3), mk_bytes(2)});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, run hung");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int accepted;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(pick_valid == 4'h0 && fetch_ready && pick_adv == 2'd0, "R11",
        256'({pick_valid, fetch_ready, pick_adv}), 256'({4'h0, 1'b1, 2'd0}));

    for (int i = 0; i < NV; i++) run_vec(i);

    // R1 and R7: fill with unterminated bytes, nothing may retire or pick.
    do_flush();
    accepted = 0;
    for (int n = 0; n < 30; n++) begin
      if (!fetch_ready) break;
      fetch_valid = 1'b1;
      fetch_bytes = mk_bytes(n);
      fetch_ends  = 16'h0000;
      fetch_skip  = 4'd0;
      @(negedge clk);
      accepted++;
    end
    fetch_valid = 1'b0;
    chk(accepted == 19, "R1", 256'(accepted), 256'(19));
    chk(!fetch_ready, "R1", 256'(fetch_ready), 256'(0));
    // A chunk offered while not ready must not change anything.
    fetch_valid = 1'b1;
    fetch_ends  = 16'hFFFF;
    @(negedge clk);
    fetch_valid = 1'b0;
    @(negedge clk);
    chk(pick_valid == 4'h0 && pick_adv == 2'd0, "R7",
        256'({pick_valid, pick_adv}), 256'(0));
    chk(!fetch_ready, "R1", 256'(fetch_ready), 256'(0));

    // R2: flush recovers a full queue; new chunk picked from byte 0.
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    chk(fetch_ready && pick_valid == 4'h0, "R2",
        256'({fetch_ready, pick_valid}), 256'({1'b1, 4'h0}));
    fetch_valid = 1'b1;
    fetch_bytes = mk_bytes(50);
    fetch_ends  = 16'h8888;
    fetch_skip  = 4'd0;
    @(negedge clk);
    fetch_valid = 1'b0;
    @(negedge clk);
    chk(got() == {4'hF, 2'd1, 20'({5'd12,5'd8,5'd4,5'd0}),
                  24'({6'd4,6'd4,6'd4,6'd4})}, "R2",
        256'(got()), 256'({4'hF, 2'd1, 20'({5'd12,5'd8,5'd4,5'd0}),
                           24'({6'd4,6'd4,6'd4,6'd4})}));
    chk(pick_window == {128'h0, mk_bytes(50)}, "R3",
        pick_window, {128'h0, mk_bytes(50)});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule